// File: doc/BRIEF.md
# Serial Transmit Character Framer

This block turns one byte at a time into an asynchronous serial character on a single output line. The character starts with a low start bit. Between five and eight data bits follow, least significant first. After them comes an optional extra bit, then a stop period. The extra bit can be one of three things: a computed even or odd parity bit, a constant of the caller's choice, or an address/data marker for multidrop networks where sleeping receivers wake only on address characters. The stop period can be one, one and a half or two bit times long. There is also a short stop of 9/16 of a bit.

All timing comes from an external tick at sixteen times the bit rate. One bit lasts sixteen ticks, so every stop length is a whole number of ticks. A one-byte holding register sits in front of the shift register. The feeding logic can therefore hand over the next byte while the current one is still on the line, and characters can then leave back to back with no idle gap. An optional clear-to-send gate holds back the start of a new character while the active-low CTS input is high.

Top module: `serial_tx_framer`

## Requirements
- R1: During and after reset `txd` is 1, `busy` is 0 and `ready` is 1. Whenever `busy` is 0, `txd` is 1.
- R2: A `loadStb` pulse while `ready` is 1 captures `loadData` and `wakeAddr` into the holding register, and `ready` is 0 on the next cycle. A `loadStb` while `ready` is 0 is ignored: the held byte is the one sent, and no further character follows it.
- R3: With a byte held and the shifter idle, a character starts on the next `baudTick`. `txd` drives the start bit at 0 for 16 ticks. `ready` returns to 1 in the cycle after the start.
- R4: `dataLenSel` sets the data bit count: 00 gives 5 bits, 01 gives 6, 10 gives 7, 11 gives 8. The bits follow the start bit least significant first, 16 ticks each, and higher bits of `loadData` are not sent.
- R5: With `parityMode` 00 a parity bit follows the data. For `parityType` 0 it is the XOR of the sent data bits (even parity). For `parityType` 1 it is the inverse of that XOR (odd parity).
- R6: With `parityMode` 01 the bit after the data is the constant `parityType`.
- R7: With `parityMode` 11 the bit after the data is `wakeAddr` XOR `parityType`, using the `wakeAddr` captured with the byte. With `parityType` 0 an address character (`wakeAddr` 1) carries a 1.
- R8: With `parityMode` 10 no bit is inserted, and the stop period follows the last data bit directly.
- R9: `stopSel` sets the high stop period: 00 gives 16 ticks, 01 gives 24, 10 gives 32, 11 gives 9. `busy` drops at the end of the stop period when no byte is waiting.
- R10: With `ctsGateEn` 1, no character starts while `ctsN` is 1. With `ctsGateEn` 0, `ctsN` has no effect.
- R11: If a byte is held when the stop period ends, its start bit begins on that same tick, and `busy` stays 1 between the two characters.
- R12: `txd` and `busy` change only on cycles with `baudTick` high. A character with N ticks therefore spans exactly N ticks whatever the spacing between ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| loadStb | input | 1 | Offers `loadData` to the holding register |
| loadData | input | 8 | Byte to send |
| wakeAddr | input | 1 | Address (1) or data (0) marker for multidrop mode |
| ctsGateEn | input | 1 | Enables start gating by `ctsN` |
| ctsN | input | 1 | Clear to send, active low |
| dataLenSel | input | 2 | Data bit count select |
| parityMode | input | 2 | Extra bit mode select |
| parityType | input | 1 | Parity sense, forced value or marker polarity |
| stopSel | input | 2 | Stop period select |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | A character is on the line |
| ready | output | 1 | Holding register empty |

## Verification
The bound checker watches the rules that hold on every cycle. These are: the line is high whenever it is idle, a start always opens with a low level, a byte offered while `ready` is high is taken, an active CTS gate blocks any start, and the outputs stay still on cycles without a tick. Bit values, parity sense, marker polarity, data length, the exact stop length and back-to-back chaining depend on the byte and the mode settings. Only the bench's sweep across every length, mode, polarity and stop setting can show these, along with its gated, chained and sparse-tick scenarios.

// File: rtl/txf_pkg.sv
package txf_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } txState_e;

  // Strobes from the sequencer to the datapath, at most one high per cycle
  typedef struct packed {
    logic startFrame;
    logic nextData;
    logic sendPar;
    logic sendStop;
  } txStrobe_t;

  localparam logic [1:0] PM_PARITY = 2'b00;
  localparam logic [1:0] PM_FORCE  = 2'b01;
  localparam logic [1:0] PM_NONE   = 2'b10;
  localparam logic [1:0] PM_WAKE   = 2'b11;

endpackage

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       holdFull,
  input  logic       ctsGateEn,
  input  logic       ctsN,
  input  logic [1:0] dataLenSel,
  input  logic [1:0] parityMode,
  input  logic [1:0] stopSel,
  output txStrobe_t  strobe,
  output logic       busy
);

  localparam int CNT_W = $clog2(2 * OVS);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);

  function automatic logic [CNT_W-1:0] stopLast(input logic [1:0] sel);
    case (sel)
      2'b00:   return CNT_W'(OVS - 1);
      2'b01:   return CNT_W'(OVS + OVS / 2 - 1);
      2'b10:   return CNT_W'(2 * OVS - 1);
      default: return CNT_W'((OVS * 9) / 16 - 1);
    endcase
  endfunction

  txState_e         state, stateNext;
  logic [CNT_W-1:0] tickCnt, tickNext;
  logic [2:0]       bitCnt, bitNext;
  logic [1:0]       lenQ, lenNext;
  logic [1:0]       stopQ, stopNext;
  logic             parOnQ, parOnNext;
  logic             canStart;
  logic             doStart;

  assign canStart = holdFull && (!ctsGateEn || !ctsN);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    tickNext  = tickCnt;
    bitNext   = bitCnt;
    lenNext   = lenQ;
    stopNext  = stopQ;
    parOnNext = parOnQ;
    doStart   = 1'b0;
    if (baudTick) begin
      if (state == ST_IDLE) begin
        doStart = canStart;
      end else if (tickCnt != '0) begin
        tickNext = tickCnt - 1'b1;
      end else begin
        case (state)
          ST_START: begin
            strobe.nextData = 1'b1;
            stateNext       = ST_DATA;
            tickNext        = BIT_LAST;
            bitNext         = 3'd4 + {1'b0, lenQ};
          end
          ST_DATA: begin
            if (bitCnt != 3'd0) begin
              strobe.nextData = 1'b1;
              bitNext         = bitCnt - 3'd1;
              tickNext        = BIT_LAST;
            end else if (parOnQ) begin
              strobe.sendPar = 1'b1;
              stateNext      = ST_PAR;
              tickNext       = BIT_LAST;
            end else begin
              strobe.sendStop = 1'b1;
              stateNext       = ST_STOP;
              tickNext        = stopLast(stopQ);
            end
          end
          ST_PAR: begin
            strobe.sendStop = 1'b1;
            stateNext       = ST_STOP;
            tickNext        = stopLast(stopQ);
          end
          ST_STOP: begin
            if (canStart) doStart = 1'b1;
            else          stateNext = ST_IDLE;
          end
          default: stateNext = ST_IDLE;
        endcase
      end
    end
    if (doStart) begin
      strobe.startFrame = 1'b1;
      stateNext         = ST_START;
      tickNext          = BIT_LAST;
      lenNext           = dataLenSel;
      stopNext          = stopSel;
      parOnNext         = (parityMode != PM_NONE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      lenQ    <= '0;
      stopQ   <= '0;
      parOnQ  <= 1'b0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickNext;
      bitCnt  <= bitNext;
      lenQ    <= lenNext;
      stopQ   <= stopNext;
      parOnQ  <= parOnNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/txf_datapath.sv
module txf_datapath
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [DATA_W-1:0] loadData,
  input  logic              wakeAddr,
  input  logic [1:0]        dataLenSel,
  input  logic [1:0]        parityMode,
  input  logic              parityType,
  input  txStrobe_t         strobe,
  output logic              txd,
  output logic              holdFull
);

  logic [DATA_W-1:0] holdData;
  logic              holdAddr;
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic              txdQ;
  logic [DATA_W-1:0] lenMask;
  logic              parCalc;

  // Bits beyond the selected length take no part in parity
  assign lenMask = {DATA_W{1'b1}} >> (2'd3 - dataLenSel);

  always_comb begin
    case (parityMode)
      PM_PARITY: parCalc = (^(holdData & lenMask)) ^ parityType;
      PM_FORCE:  parCalc = parityType;
      PM_WAKE:   parCalc = holdAddr ^ parityType;
      default:   parCalc = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      holdAddr <= 1'b0;
      holdFull <= 1'b0;
      shiftReg <= '0;
      parBit   <= 1'b1;
      txdQ     <= 1'b1;
    end else begin
      if (strobe.startFrame) begin
        holdFull <= 1'b0;
        shiftReg <= holdData;
        parBit   <= parCalc;
        txdQ     <= 1'b0;
      end else if (loadStb && !holdFull) begin
        holdFull <= 1'b1;
        holdData <= loadData;
        holdAddr <= wakeAddr;
      end
      if (strobe.nextData) begin
        txdQ     <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end
      if (strobe.sendPar)  txdQ <= parBit;
      if (strobe.sendStop) txdQ <= 1'b1;
    end
  end

  assign txd = txdQ;

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
  import txf_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       loadStb,
  input  logic [7:0] loadData,
  input  logic       wakeAddr,
  input  logic       ctsGateEn,
  input  logic       ctsN,
  input  logic [1:0] dataLenSel,
  input  logic [1:0] parityMode,
  input  logic       parityType,
  input  logic [1:0] stopSel,
  output logic       txd,
  output logic       busy,
  output logic       ready
);

  txStrobe_t strobe;
  logic      holdFull;

  txf_ctrl #(.OVS(OVS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .baudTick   (baudTick),
    .holdFull   (holdFull),
    .ctsGateEn  (ctsGateEn),
    .ctsN       (ctsN),
    .dataLenSel (dataLenSel),
    .parityMode (parityMode),
    .stopSel    (stopSel),
    .strobe     (strobe),
    .busy       (busy)
  );

  txf_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .loadStb    (loadStb),
    .loadData   (loadData),
    .wakeAddr   (wakeAddr),
    .dataLenSel (dataLenSel),
    .parityMode (parityMode),
    .parityType (parityType),
    .strobe     (strobe),
    .txd        (txd),
    .holdFull   (holdFull)
  );

  assign ready = !holdFull;

endmodule

// File: rtl/serial_tx_framer_chk.sv
module serial_tx_framer_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic loadStb,
  input logic ctsGateEn,
  input logic ctsN,
  input logic txd,
  input logic busy,
  input logic ready
);

  // R1: an idle line sits high
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txd);

  // R2: an offered byte is taken when the holder is empty
  a_r2_load_taken: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && ready) |=> !ready);

  // R3: every character opens with a low start level
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txd);

  // R10: an active gate with CTS negated blocks a start
  a_r10_cts_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ctsGateEn && ctsN) |=> !busy);

  // R12: nothing on the line moves without a tick
  a_r12_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> ($stable(txd) && $stable(busy)));

endmodule

bind serial_tx_framer serial_tx_framer_chk u_chk (.*);

// File: tb/sim_serial_tx_framer.sv
`timescale 1ns/1ps
module sim_serial_tx_framer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic loadStb = 1'b0;
  logic [7:0] loadData = '0;
  logic wakeAddr = 1'b0;
  logic ctsGateEn = 1'b0;
  logic ctsN = 1'b1;
  logic [1:0] dataLenSel = 2'd3;
  logic [1:0] parityMode = 2'd0;
  logic parityType = 1'b0;
  logic [1:0] stopSel = 2'd0;
  logic txd, busy, ready;

  int nChk = 0;
  int nBad = 0;
  int tickDiv = 1;
  int tickPh = 0;

  serial_tx_framer u0 (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .loadStb(loadStb),
    .loadData(loadData), .wakeAddr(wakeAddr), .ctsGateEn(ctsGateEn),
    .ctsN(ctsN), .dataLenSel(dataLenSel), .parityMode(parityMode),
    .parityType(parityType), .stopSel(stopSel), .txd(txd), .busy(busy),
    .ready(ready)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tickDiv <= 1) begin
      baudTick = 1'b1;
    end else begin
      baudTick = (tickPh == 0);
      tickPh = (tickPh + 1) % tickDiv;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int frameLen(input logic [1:0] len, input logic [1:0] pm, input logic [1:0] st);
    int s;
    case (st)
      2'd0: s = 16;
      2'd1: s = 24;
      2'd2: s = 32;
      default: s = 9;
    endcase
    return 16 * (1 + 5 + int'(len) + ((pm != 2'd2) ? 1 : 0)) + s;
  endfunction

  function automatic bit expBit(input int k, input logic [7:0] d, input bit a,
                                input logic [1:0] len, input logic [1:0] pm, input bit pt);
    int nd;
    int idx;
    logic [7:0] m;
    nd = 5 + int'(len);
    idx = k / 16;
    m = 8'hFF >> (3 - int'(len));
    if (idx == 0) return 1'b0;
    if (idx <= nd) return d[idx-1];
    if (idx == nd + 1 && pm != 2'd2) begin
      case (pm)
        2'd0: return (^(d & m)) ^ pt;
        2'd1: return pt;
        default: return a ^ pt;
      endcase
    end
    return 1'b1;
  endfunction

  task automatic loadByte(input logic [7:0] d, input bit a);
    @(negedge clk);
    loadData = d;
    wakeAddr = a;
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic checkFrame(input logic [7:0] d, input bit a, input bit skipWait,
                            input bit hasNext, input logic [7:0] nd, input bit na,
                            input string tag);
    int waitCnt;
    int bad;
    int firstBad;
    int actV;
    int expV;
    int len;
    bit e;
    waitCnt = 0;
    bad = 0;
    firstBad = -1;
    actV = 0;
    expV = 0;
    len = frameLen(dataLenSel, parityMode, stopSel);
    if (!skipWait) begin
      while (txd !== 1'b0 && waitCnt < 300) begin
        @(negedge clk);
        waitCnt++;
      end
    end
    chk(ready === 1'b1, {"R3 ready after start ", tag}, ready, 1);
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0 && hasNext) begin
        loadData = nd;
        wakeAddr = na;
        loadStb = 1'b1;
      end
      if (k == 1) loadStb = 1'b0;
      e = expBit(k, d, a, dataLenSel, parityMode, parityType);
      if (txd !== e || busy !== 1'b1) begin
        if (bad == 0) begin
          firstBad = k;
          actV = (busy !== 1'b1) ? 9 : int'(txd);
          expV = int'(e);
        end
        bad++;
      end
    end
    chk(bad == 0, $sformatf("%s waveform at tick %0d", tag, firstBad), actV, expV);
    @(negedge clk);
    if (hasNext)
      chk(busy === 1'b1 && txd === 1'b0, {"R11 next start follows stop ", tag}, txd, 0);
    else
      chk(busy === 1'b0 && txd === 1'b1, {"R9 busy ends after stop ", tag}, busy, 0);
  endtask

  initial begin
    string modeTag [4];
    int idx;
    int cnt;
    int expLen;
    modeTag[0] = "R5";
    modeTag[1] = "R6";
    modeTag[2] = "R8";
    modeTag[3] = "R7";

    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0 && ready === 1'b1, "R1 state in reset", txd, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0 && ready === 1'b1, "R1 state after reset", busy, 0);

    // Full sweep of format settings; CTS negated but gating off (R10)
    idx = 0;
    for (int len = 0; len < 4; len++) begin
      for (int pm = 0; pm < 4; pm++) begin
        for (int pt = 0; pt < 2; pt++) begin
          for (int st = 0; st < 4; st++) begin
            logic [7:0] d;
            bit a;
            d = 8'hA5 ^ 8'(idx * 37);
            a = idx[1];
            @(negedge clk);
            dataLenSel = 2'(len);
            parityMode = 2'(pm);
            parityType = pt[0];
            stopSel = 2'(st);
            loadByte(d, a);
            checkFrame(d, a, 1'b0, 1'b0, 8'h00, 1'b0,
              $sformatf("R4 R9 R10 %s len=%0d pm=%0d pt=%0d st=%0d d=%0h",
                        modeTag[pm], len, pm, pt, st, d));
            idx++;
          end
        end
      end
    end

    // Gate active: held byte waits, second offer ignored
    @(negedge clk);
    dataLenSel = 2'd3;
    parityMode = 2'd2;
    parityType = 1'b0;
    stopSel = 2'd0;
    ctsGateEn = 1'b1;
    ctsN = 1'b1;
    loadByte(8'h3C, 1'b0);
    repeat (40) @(negedge clk);
    chk(busy === 1'b0 && txd === 1'b1, "R10 gated start held off", busy, 0);
    chk(ready === 1'b0, "R2 ready low while byte held", ready, 0);
    loadByte(8'hC3, 1'b0);
    ctsN = 1'b0;
    checkFrame(8'h3C, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R2 R10 held byte sent");
    repeat (40) @(negedge clk);
    chk(busy === 1'b0 && ready === 1'b1, "R2 ignored byte not queued", busy, 0);
    ctsGateEn = 1'b0;
    ctsN = 1'b1;

    // Back to back in wake-up mode with short stop
    @(negedge clk);
    dataLenSel = 2'd0;
    parityMode = 2'd3;
    parityType = 1'b1;
    stopSel = 2'd3;
    loadByte(8'h15, 1'b1);
    checkFrame(8'h15, 1'b1, 1'b0, 1'b1, 8'h0A, 1'b0, "R11 R7 first char");
    checkFrame(8'h0A, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R11 R7 second char");

    // Sparse ticks: one in three cycles
    @(negedge clk);
    tickDiv = 3;
    dataLenSel = 2'd3;
    parityMode = 2'd0;
    parityType = 1'b0;
    stopSel = 2'd1;
    expLen = 3 * frameLen(2'd3, 2'd0, 2'd1);
    loadByte(8'h81, 1'b0);
    cnt = 0;
    while (txd !== 1'b0 && cnt < 300) begin
      @(negedge clk);
      cnt++;
    end
    cnt = 0;
    while (busy === 1'b1 && cnt < 2000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == expLen, "R12 frame spans ticks not cycles", cnt, expLen);
    chk(txd === 1'b1, "R12 line high after sparse frame", txd, 1);
    tickDiv = 1;

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog R1-wide run actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule